// File: doc/BRIEF.md
# Radix-4 SRT Mantissa Divider

This block divides one normalized mantissa by another with a digit-recurrence method. Each iteration retires two quotient bits. Both operands lie in [1,2) and arrive as fraction fields only, because the leading integer one is implied. A single-cycle `start` pulse captures the operands while the unit is idle. The block then runs a fixed number of iterations and raises `done` for one cycle. In that cycle a non-redundant quotient and a non-negative remainder are presented.

The residual is kept as a pair of sum and carry vectors, so each iteration costs only one row of full adders. A small selection function looks at a truncated estimate of four times the residual and a truncated divisor. From these it picks a signed digit in -2..+2. The divisor multiple for that digit is formed by shifting and inverting the divisor, then folded into the residual. Positive and negative digits are collected in two separate vectors. At the end, one subtraction merges them, one full addition resolves the residual, and a one-ulp correction is applied if the residual came out negative.

With `F` fraction bits per operand, the unit runs `N = (F+3)/2` iterations. Write `X = {1,dividend_frac}` and `D = {1,divisor_frac}` as integers. The outputs then satisfy `X * 4^(N-1) = quotient * D + remainder`. The quotient has `2N-2` fraction bits, which is 14 bits at the default `F = 14`.

Top module: `srt4_divider`

## Requirements
- R1: The quotient equals floor(X * 4^(N-1) / D), where X and D are the operands with their implied leading one, read as integers. For equal operands the quotient is exactly 2^(2N-2).
- R2: The remainder equals X * 4^(N-1) - quotient * D and satisfies 0 <= remainder < D.
- R3: A start accepted at a rising edge raises `done` in the cycle after the (N+1)-th following edge. `busy` is high from the accepting edge until the edge that raises `done`.
- R4: `done` is high for exactly one cycle, and `quotient` and `remainder` hold their values until the next `done`.
- R5: A `start` while `busy` is high is ignored: the run in progress keeps its operands and timing.
- R6: A `start` in the cycle where `done` is high is accepted, so operations can run back to back.
- R7: A synchronous active-high reset clears `busy`, `done`, `quotient` and `remainder` to zero and abandons any run in progress without a later `done`.
- R8: Between iterations the resolved residual w satisfies |w| <= (2/3)*D, starting from a first residual equal to the dividend shifted right by 2.
- R9: Each iteration makes the resolved residual equal to 4*w - q*D, with q in -2..+2, using only the multiples 0, ±D and ±2D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle request to begin a division |
| dividend_frac | input | FRAC_W | Fraction bits of the dividend (leading one implied) |
| divisor_frac | input | FRAC_W | Fraction bits of the divisor (leading one implied) |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | Single-cycle pulse marking a valid result |
| quotient | output | 2N-1 | Quotient, one integer bit and 2N-2 fraction bits |
| remainder | output | FRAC_W+1 | Non-negative remainder, smaller than the divisor |

## Verification
The end of one operation and the start of the next can land in the same cycle. The bench drives `start` with fresh operands in exactly the cycle where `done` is seen high. It then expects `busy` on the next cycle, and a second result that belongs to the new operands and arrives at the full latency. A second collision, a `start` arriving while an iteration is in flight, is provoked by re-requesting with different operands a few cycles into a run. That case is judged by the first result still matching the original operands at unchanged timing. A per-cycle behavioural model compares `busy`, `done`, `quotient` and `remainder` throughout.

// File: rtl/srt4_pkg.sv
package srt4_pkg;

    // Estimate precision used by digit selection
    localparam int EST_FRAC = 7;             // fraction bits of the 4w estimate
    localparam int EST_W    = 4 + EST_FRAC;  // sign + 3 integer bits + fraction
    localparam int DIV_EST  = 6;             // divisor fraction bits seen by selection

    typedef logic signed [2:0] digit_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIN
    } phase_t;

    // Pick a digit by comparing the residual estimate with (k - 1/2) * dhat.
    // y is in units of 2^-EST_FRAC, dh in units of 2^-DIV_EST (EST_FRAC = DIV_EST + 1).
    function automatic digit_t select_digit(input logic signed [15:0] y,
                                            input logic [7:0] dh);
        int yi;
        int di;
        int hits;
        digit_t q;
        yi   = int'(y);
        di   = int'(dh);
        hits = 0;
        if (yi >= 3 * di)  hits = hits + 1;
        if (yi >= di)      hits = hits + 1;
        if (yi >= -di)     hits = hits + 1;
        if (yi >= -3 * di) hits = hits + 1;
        q = 3'(hits - 2);
        return q;
    endfunction

endpackage

// File: rtl/srt4_qsel.sv
module srt4_qsel
    import srt4_pkg::*;
(
    input  logic [EST_W-1:0]   est_sum,
    input  logic [EST_W-1:0]   est_cry,
    input  logic [DIV_EST:0]   div_top,
    output digit_t             digit
);

    logic signed [EST_W-1:0] est_y;
    logic signed [15:0]      est_wide;

    always_comb begin
        est_y    = signed'(est_sum + est_cry);
        est_wide = {{(16 - EST_W){est_y[EST_W-1]}}, est_y};
        digit    = select_digit(est_wide, {{(7 - DIV_EST){1'b0}}, div_top});
    end

endmodule

// File: rtl/srt4_multiple.sv
module srt4_multiple
    import srt4_pkg::*;
#(
    parameter int RES_W = 20
) (
    input  logic [RES_W-1:0] div_res,
    input  digit_t           digit,
    output logic [RES_W-1:0] addend,
    output logic             inject
);

    logic [RES_W-1:0] magnitude;
    logic             negative;

    always_comb begin
        negative = digit[2];
        if (digit == 3'sd2 || digit == -3'sd2) begin
            magnitude = div_res << 1;
        end else if (digit == 3'sd1 || digit == -3'sd1) begin
            magnitude = div_res;
        end else begin
            magnitude = '0;
        end
        // subtracting a positive multiple = add its one's complement plus one
        addend = negative ? magnitude : ~magnitude;
        inject = ~negative;
        if (digit == 3'sd0) begin
            addend = '0;
            inject = 1'b0;
        end
    end

endmodule

// File: rtl/srt4_csa.sv
module srt4_csa #(
    parameter int W = 20
) (
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] in_c,
    input  logic         cin,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] cry_o
);

    logic [W-2:0] maj;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_fa
            assign sum_o[i] = in_a[i] ^ in_b[i] ^ in_c[i];
            if (i < W - 1) begin : g_cy
                assign maj[i] = (in_a[i] & in_b[i]) | (in_a[i] & in_c[i]) | (in_b[i] & in_c[i]);
            end
        end
    endgenerate

    assign cry_o = {maj, cin};

endmodule

// File: rtl/srt4_assemble.sv
module srt4_assemble #(
    parameter int QACC_W = 16,
    parameter int RES_W  = 20
) (
    input  logic [QACC_W-1:0] q_pos,
    input  logic [QACC_W-1:0] q_neg,
    input  logic [RES_W-1:0]  w_sum,
    input  logic [RES_W-1:0]  w_cry,
    input  logic [RES_W-1:0]  div_res,
    output logic [QACC_W:0]   q_fixed,
    output logic [RES_W-1:0]  w_fixed
);

    logic [QACC_W:0]  q_raw;
    logic [RES_W-1:0] w_raw;
    logic             w_neg;

    always_comb begin
        q_raw   = {1'b0, q_pos} - {1'b0, q_neg};
        w_raw   = w_sum + w_cry;
        w_neg   = w_raw[RES_W-1];
        q_fixed = q_raw - {{QACC_W{1'b0}}, w_neg};
        w_fixed = w_raw + (w_neg ? div_res : {RES_W{1'b0}});
    end

endmodule

// File: rtl/srt4_divider.sv
module srt4_divider
    import srt4_pkg::*;
#(
    parameter int FRAC_W = 14,
    localparam int N_DIG  = (FRAC_W + 3) / 2,
    localparam int MANT_W = FRAC_W + 1,
    localparam int QUO_W  = 2 * N_DIG - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [FRAC_W-1:0] dividend_frac,
    input  logic [FRAC_W-1:0] divisor_frac,
    output logic              busy,
    output logic              done,
    output logic [QUO_W-1:0]  quotient,
    output logic [MANT_W-1:0] remainder
);

    localparam int RF     = FRAC_W + 2;
    localparam int RES_W  = RF + 4;
    localparam int QACC_W = 2 * N_DIG;
    localparam int CNT_W  = $clog2(N_DIG + 1);

    typedef struct packed {
        logic [RES_W-1:0] sum;
        logic [RES_W-1:0] cry;
    } resid_t;

    phase_t             phase;
    logic [CNT_W-1:0]   iter;
    resid_t             res_q;
    resid_t             res_n;
    logic [RES_W-1:0]   d_res;
    logic [QACC_W-1:0]  qp_q;
    logic [QACC_W-1:0]  qn_q;
    logic [QUO_W-1:0]   quo_q;
    logic [MANT_W-1:0]  rem_q;
    logic               done_q;

    digit_t             dig;
    logic [RES_W-1:0]   addend;
    logic               inject;
    logic [QACC_W:0]    q_fixed;
    logic [RES_W-1:0]   w_fixed;
    logic [1:0]         pos_bits;
    logic [1:0]         neg_bits;
    digit_t             dig_neg;

    // ---------------- digit selection ----------------
    srt4_qsel u_qsel (
        .est_sum (res_q.sum[RES_W-3 -: EST_W]),
        .est_cry (res_q.cry[RES_W-3 -: EST_W]),
        .div_top (d_res[RF -: DIV_EST + 1]),
        .digit   (dig)
    );

    // ---------------- divisor multiple ----------------
    srt4_multiple #(.RES_W(RES_W)) u_mult (
        .div_res (d_res),
        .digit   (dig),
        .addend  (addend),
        .inject  (inject)
    );

    // ---------------- carry-save step ----------------
    srt4_csa #(.W(RES_W)) u_csa (
        .in_a  (res_q.sum << 2),
        .in_b  (res_q.cry << 2),
        .in_c  (addend),
        .cin   (inject),
        .sum_o (res_n.sum),
        .cry_o (res_n.cry)
    );

    // ---------------- final assembly ----------------
    srt4_assemble #(.QACC_W(QACC_W), .RES_W(RES_W)) u_asm (
        .q_pos   (qp_q),
        .q_neg   (qn_q),
        .w_sum   (res_q.sum),
        .w_cry   (res_q.cry),
        .div_res (d_res),
        .q_fixed (q_fixed),
        .w_fixed (w_fixed)
    );

    always_comb begin
        dig_neg  = -dig;
        pos_bits = (dig > 3'sd0) ? dig[1:0] : 2'b00;
        neg_bits = (dig < 3'sd0) ? dig_neg[1:0] : 2'b00;
    end

    // ---------------- control and registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= ST_IDLE;
            iter   <= '0;
            res_q  <= '0;
            d_res  <= '0;
            qp_q   <= '0;
            qn_q   <= '0;
            quo_q  <= '0;
            rem_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase)
                ST_IDLE: begin
                    if (start) begin
                        res_q.sum <= {5'b00000, 1'b1, dividend_frac};
                        res_q.cry <= '0;
                        d_res     <= {3'b000, 1'b1, divisor_frac, 2'b00};
                        qp_q      <= '0;
                        qn_q      <= '0;
                        iter      <= '0;
                        phase     <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    res_q <= res_n;
                    qp_q  <= {qp_q[QACC_W-3:0], pos_bits};
                    qn_q  <= {qn_q[QACC_W-3:0], neg_bits};
                    iter  <= iter + 1'b1;
                    if (iter == CNT_W'(N_DIG - 1)) begin
                        phase <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    quo_q  <= q_fixed[QUO_W-1:0];
                    rem_q  <= w_fixed[2 +: MANT_W];
                    done_q <= 1'b1;
                    phase  <= ST_IDLE;
                end
                default: phase <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (phase != ST_IDLE);
    assign done      = done_q;
    assign quotient  = quo_q;
    assign remainder = rem_q;

    // ---------------- assertions ----------------
    logic [RES_W-1:0]        w_plain;
    logic [RES_W-1:0]        nxt_ref;
    logic signed [RES_W-1:0] w_now;
    logic signed [RES_W+2:0] w_wide;
    logic signed [RES_W+2:0] w_abs;
    logic signed [RES_W+2:0] w_abs3;
    logic signed [RES_W+2:0] d_two;

    always_comb begin
        w_plain = res_q.sum + res_q.cry;
        if (dig == 3'sd2)       nxt_ref = (w_plain << 2) - (d_res << 1);
        else if (dig == 3'sd1)  nxt_ref = (w_plain << 2) - d_res;
        else if (dig == -3'sd1) nxt_ref = (w_plain << 2) + d_res;
        else if (dig == -3'sd2) nxt_ref = (w_plain << 2) + (d_res << 1);
        else                    nxt_ref = w_plain << 2;
        w_now  = signed'(w_plain);
        w_wide = {{3{w_now[RES_W-1]}}, w_now};
        w_abs  = (w_wide < 0) ? -w_wide : w_wide;
        w_abs3 = (w_abs <<< 1) + w_abs;
        d_two  = signed'({2'b00, d_res, 1'b0});
    end

    AST_RESID_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase != ST_IDLE) |-> (w_abs3 <= d_two)) else $error("residual out of bound"); // R8

    AST_CSA_STEP: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_RUN) |=> ((res_q.sum + res_q.cry) == $past(nxt_ref))) else $error("recurrence broken"); // R9

    AST_DIGIT_SET: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_RUN) |-> (dig >= -3'sd2 && dig <= 3'sd2)) else $error("digit outside set"); // R9

    AST_QUO_FITS: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_FIN) |-> (q_fixed[QACC_W:QUO_W] == '0)) else $error("quotient overflow"); // R1

    AST_REM_RANGE: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_FIN) |-> (w_fixed[RES_W-1:MANT_W+2] == '0 && w_fixed[1:0] == 2'b00
                               && w_fixed[2 +: MANT_W] < d_res[2 +: MANT_W])) else $error("remainder range"); // R2

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_FIN) |-> (iter == CNT_W'(N_DIG))) else $error("iteration count"); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done longer than one cycle"); // R4

    AST_OPERAND_HOLD: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(d_res)) else $error("operands changed while busy"); // R5

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!busy && !done && quotient == '0)) else $error("reset state"); // R7

endmodule

// File: tb/sim_srt4_divider.sv
module sim_srt4_divider;

    localparam int FRAC_W = 14;
    localparam int N_DIG  = (FRAC_W + 3) / 2;
    localparam int MANT_W = FRAC_W + 1;
    localparam int QUO_W  = 2 * N_DIG - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [FRAC_W-1:0] xf = '0;
    logic [FRAC_W-1:0] df = '0;
    logic              busy;
    logic              done;
    logic [QUO_W-1:0]  quotient;
    logic [MANT_W-1:0] remainder;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    srt4_divider #(.FRAC_W(FRAC_W)) u0 (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .dividend_frac (xf),
        .divisor_frac  (df),
        .busy          (busy),
        .done          (done),
        .quotient      (quotient),
        .remainder     (remainder)
    );

    function automatic longint ref_quo(input logic [FRAC_W-1:0] a, input logic [FRAC_W-1:0] b);
        longint num, den;
        num = longint'({1'b1, a}) << (2 * (N_DIG - 1));
        den = longint'({1'b1, b});
        return num / den;
    endfunction

    function automatic longint ref_rem(input logic [FRAC_W-1:0] a, input logic [FRAC_W-1:0] b);
        longint num, den;
        num = longint'({1'b1, a}) << (2 * (N_DIG - 1));
        den = longint'({1'b1, b});
        return num % den;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference, advanced on each rising edge ----------------
    bit     armed = 1'b0;
    bit     m_busy = 1'b0;
    bit     m_done = 1'b0;
    int     m_cnt = 0;
    longint m_quo = 0, m_rem = 0, p_quo = 0, p_rem = 0;

    always @(posedge clk) begin
        armed = 1'b1;
        if (rst) begin
            m_busy = 1'b0; m_done = 1'b0; m_cnt = 0; m_quo = 0; m_rem = 0;
        end else begin
            m_done = 1'b0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == N_DIG + 1) begin
                    m_busy = 1'b0; m_done = 1'b1; m_quo = p_quo; m_rem = p_rem;
                end
            end else if (start) begin
                m_busy = 1'b1; m_cnt = 0;
                p_quo = ref_quo(xf, df);
                p_rem = ref_rem(xf, df);
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (armed) begin
            chk(busy == m_busy, "R3 busy", busy, m_busy);
            chk(done == m_done, "R3 done timing", done, m_done);
            chk(longint'(quotient) == m_quo, "R1/R4 quotient", quotient, m_quo);
            chk(longint'(remainder) == m_rem, "R2/R4 remainder", remainder, m_rem);
        end
    end

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic run_div(input logic [FRAC_W-1:0] a, input logic [FRAC_W-1:0] b, input string tag);
        @(negedge clk);
        start = 1'b1; xf = a; df = b;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk(longint'(quotient) == ref_quo(a, b), tag, quotient, ref_quo(a, b));
        chk(longint'(remainder) == ref_rem(a, b), "R2 remainder", remainder, ref_rem(a, b));
        @(negedge clk);
        chk(done == 1'b0, "R4 single-cycle done", done, 0);
    endtask

    // watchdog
    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [FRAC_W-1:0] ax, ad;
        longint qa;
        repeat (3) @(negedge clk);
        // R7: reset state
        chk(busy == 1'b0 && done == 1'b0, "R7 reset busy/done", {busy, done}, 0);
        chk(quotient == '0, "R7 reset quotient", quotient, 0);
        rst = 1'b0;

        // R1: equal operands give exactly one
        run_div('0, '0, "R1 one");
        chk(quotient == QUO_W'(1 << (2 * N_DIG - 2)), "R1 unity", quotient, 1 << (2 * N_DIG - 2));
        // R8 stress: largest dividend over smallest divisor, and the reverse
        run_div('1, '0, "R1 max over min (R8)");
        run_div('0, '1, "R1 min over max (R8)");
        run_div(14'h2AAA, 14'h2AAA, "R1 equal mid");
        run_div(14'h1555, 14'h3FFE, "R1 pattern");
        // R9: random operands exercise every digit value
        for (int k = 0; k < 24; k++) begin
            run_div(FRAC_W'($urandom), FRAC_W'($urandom), "R1 random (R9)");
        end

        // R5: start while busy is ignored
        ax = 14'h0123; ad = 14'h3210;
        qa = ref_quo(ax, ad);
        @(negedge clk);
        start = 1'b1; xf = ax; df = ad;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b1; xf = 14'h3FFF; df = 14'h0001;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk(longint'(quotient) == qa, "R5 busy start ignored", quotient, qa);
        @(negedge clk);
        chk(busy == 1'b0, "R5 no second run", busy, 0);

        // R6: start in the done cycle is accepted
        @(negedge clk);
        start = 1'b1; xf = 14'h0F0F; df = 14'h00FF;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        start = 1'b1; xf = 14'h3C3C; df = 14'h1234;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R6 back-to-back accepted", busy, 1);
        wait_done();
        chk(longint'(quotient) == ref_quo(14'h3C3C, 14'h1234), "R6 second result",
            quotient, ref_quo(14'h3C3C, 14'h1234));

        // R4: outputs hold while idle
        qa = ref_quo(14'h3C3C, 14'h1234);
        repeat (6) @(negedge clk);
        chk(longint'(quotient) == qa, "R4 quotient held", quotient, qa);

        // R7: reset mid-run abandons the operation
        start = 1'b1; xf = 14'h0777; df = 14'h0555;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < N_DIG + 4; k++) begin
            chk(done == 1'b0 && busy == 1'b0, "R7 run abandoned", {busy, done}, 0);
            @(negedge clk);
        end
        run_div(14'h2001, 14'h0003, "R1 after reset");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule